// File: doc/BRIEF.md
# Real-Time Clock Once-Per-Second Update Sequencer

This block advances the seconds, minutes and hours registers of a battery-backed clock once every second. It counts ticks of a 32.768 kHz time base in a prescaler. A fixed number of ticks before each one-second boundary, it raises an update-in-progress flag, so that software knows not to read the time. At the boundary it advances the time registers. It keeps the flag high for a fixed update window and then drops it. In the same cycle that the flag drops, it pulses an update-ended event for the interrupt logic.

A three-bit divider field either runs the prescaler, freezes it, or clears it and holds it at zero. A set control stops all update cycles while software writes new time values. The prescaler keeps counting during that time, so the second boundary does not shift. The time values are kept in BCD or binary form, and the hours run in either 24-hour or 12-hour form.

Top module: `rtc_update_ctrl`

## Requirements
- R1: After reset, the seconds, minutes and hours outputs read 0, the update-in-progress output is low and the update-ended output is low.
- R2: When the prescaler is running, the update-in-progress output goes high after the tick that brings the prescaler count to TICKS_PER_SEC-LEAD_TICKS. The time outputs advance after the tick that wraps the count from TICKS_PER_SEC-1 to 0, which is exactly LEAD_TICKS ticks later.
- R3: After the advance, update-in-progress stays high for UPD_TICKS more ticks and goes low after the UPD_TICKS-th of them.
- R4: The update-ended output is high for exactly one clock cycle, in the cycle in which update-in-progress first reads low at the end of a window.
- R5: The divider field value 3'b010 runs the prescaler. The values 3'b110 and 3'b111 clear the prescaler to 0 and hold it there, with update-in-progress low. After the field returns to 3'b010, the first advance comes on the TICKS_PER_SEC-th tick.
- R6: Any other divider value freezes the prescaler at its count and keeps update-in-progress low. After 3'b010 returns, counting resumes from the frozen count.
- R7: While the set input is high, the time outputs do not advance, update-in-progress stays low and no update-ended pulse occurs. The prescaler keeps counting, so the next advance after the set input is released comes on the original one-second grid.
- R8: When load is high and set is high, the three load inputs are copied into the time registers on the next clock edge. When set is low, the load input has no effect.
- R9: When the binary input is high, seconds and minutes count 0 to 59 as plain binary values. The minutes advance when the seconds wrap from 59 to 0, and the hours advance when the minutes wrap from 59 to 0.
- R10: When the binary input is low, each time byte holds BCD: the tens digit in bits 7:4 and the units digit in bits 3:0. The units digit carries into the tens digit after 9, and 0x59 wraps to 0x00.
- R11: When the 24-hour input is high, the hours count 0 to 23 and wrap from 23 to 0.
- R12: When the 24-hour input is low, the hours count 1 to 12 in bits 6:0, and bit 7 is set for PM. The hour goes from 11 AM to 12 PM, from 12 to 1 within the same half-day, and from 11 PM to 12 AM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe for each 32.768 kHz time-base period |
| div_sel_i | input | 3 | Divider control: 010 runs the prescaler, 11x clears and holds it, other values freeze it |
| set_i | input | 1 | Stops update cycles and allows the time registers to be loaded |
| bin_i | input | 1 | 1 selects binary time values, 0 selects BCD |
| h24_i | input | 1 | 1 selects 24-hour mode, 0 selects 12-hour mode with a PM bit |
| load_i | input | 1 | Loads the time registers (only while set_i is high) |
| load_sec_i | input | 8 | Seconds value to load |
| load_min_i | input | 8 | Minutes value to load |
| load_hour_i | input | 8 | Hours value to load |
| sec_o | output | 8 | Seconds register |
| min_o | output | 8 | Minutes register |
| hour_o | output | 8 | Hours register |
| uip_o | output | 1 | Update-in-progress flag |
| upd_done_o | output | 1 | One-cycle pulse at the end of an update window |

## Verification
The bench builds the block with TICKS_PER_SEC=16, LEAD_TICKS=3 and UPD_TICKS=4. With these values a simulated second is only sixteen ticks long, so every tick of the lead window, the advance and the update window is compared against a phase computed in the bench. All four combinations of number format and hour mode are run. Each combination starts from five times chosen to cross the minute, hour, noon, midnight and BCD tens-digit boundaries. The short second also brings within reach a hold of two whole seconds under set, a freeze and resume of the divider, and the full second that follows each divider reset.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_UPD
  } upd_st_e;

  localparam logic [2:0] DIV_RUN = 3'b010;

  // encode 0..99 in the selected format
  function automatic logic [7:0] enc_val(logic bin, logic [6:0] v);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = v / 7'd10;
    ones = v % 7'd10;
    if (bin) return {1'b0, v};
    return {tens[3:0], ones[3:0]};
  endfunction

  // increment with wrap to 0 after top
  function automatic logic [7:0] step_wrap(logic bin, logic [7:0] v, logic [6:0] top);
    if (v == enc_val(bin, top)) return 8'h00;
    if (!bin && v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return 8'(v + 8'd1);
  endfunction

  function automatic logic [7:0] step_hour(logic bin, logic h24, logic [7:0] v);
    logic [7:0] h;
    logic [7:0] nxt;
    logic [7:0] twelve;
    if (h24) return step_wrap(bin, v, 7'd23);
    h      = {1'b0, v[6:0]};
    twelve = enc_val(bin, 7'd12);
    if (h == twelve) return {v[7], 7'h01};
    if (h == enc_val(bin, 7'd11)) return {~v[7], twelve[6:0]};
    nxt = step_wrap(bin, h, 7'd12);
    return {v[7], nxt[6:0]};
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_upd_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned LEAD_TICKS    = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [2:0] div_sel_i,
  output logic       run_o,
  output logic       lead_o,
  output logic       sec_o
);

  localparam int unsigned CW = $clog2(TICKS_PER_SEC);
  localparam logic [CW-1:0] LAST_CNT = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] LEAD_CNT = CW'(TICKS_PER_SEC - LEAD_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          clr;
  logic          adv;

  assign run_o = (div_sel_i == DIV_RUN);
  assign clr   = (div_sel_i[2:1] == 2'b11);
  assign adv   = run_o && tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (adv) cnt_q <= (cnt_q == LAST_CNT) ? '0 : cnt_q + 1'b1;
  end

  assign lead_o = adv && (cnt_q == LEAD_CNT);
  assign sec_o  = adv && (cnt_q == LAST_CNT);

  AST_DIV_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (cnt_q == '0)); // R5
  AST_DIV_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_o && !clr) |=> $stable(cnt_q)); // R6
  AST_SEC_NOT_LEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_o |-> !lead_o); // R2

endmodule

// File: rtl/rtc_update_fsm.sv
module rtc_update_fsm
  import rtc_upd_pkg::*;
#(
  parameter int unsigned UPD_TICKS = 65
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic set_i,
  input  logic lead_i,
  input  logic sec_i,
  output logic uip_o,
  output logic upd_o,
  output logic done_o
);

  localparam int unsigned WW = $clog2(UPD_TICKS + 1);
  localparam logic [WW-1:0] LAST_W = WW'(UPD_TICKS - 1);

  upd_st_e       st_q, st_d;
  logic [WW-1:0] w_q, w_d;
  logic          done_q, done_d;
  logic          abort;

  assign abort = !run_i || set_i;

  always_comb begin
    st_d   = st_q;
    w_d    = w_q;
    done_d = 1'b0;
    if (abort) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (lead_i) st_d = ST_LEAD;
        ST_LEAD: if (sec_i) begin
          st_d = ST_UPD;
          w_d  = '0;
        end
        ST_UPD: if (tick_i) begin
          if (w_q == LAST_W) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            w_d = w_q + 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      w_q    <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      w_q    <= w_d;
      done_q <= done_d;
    end
  end

  assign uip_o  = (st_q != ST_IDLE);
  assign upd_o  = (st_q == ST_LEAD) && sec_i && !abort;
  assign done_o = done_q;

  AST_SET_UIP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> !uip_o); // R7
  AST_UPD_IN_UIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> uip_o); // R2
  AST_DONE_ENDS_UIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!uip_o && $past(uip_o))); // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R4
  AST_UPD_STARTS_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> uip_o); // R3

endmodule

// File: rtl/rtc_time_counters.sv
module rtc_time_counters
  import rtc_upd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       upd_i,
  input  logic       load_i,
  input  logic       bin_i,
  input  logic       h24_i,
  input  logic [7:0] load_sec_i,
  input  logic [7:0] load_min_i,
  input  logic [7:0] load_hour_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o
);

  logic [7:0] sec_q, min_q, hour_q;
  logic       sec_top, min_top;

  assign sec_top = (sec_q == enc_val(bin_i, 7'd59));
  assign min_top = (min_q == enc_val(bin_i, 7'd59));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= '0;
      min_q  <= '0;
      hour_q <= '0;
    end else if (load_i) begin
      sec_q  <= load_sec_i;
      min_q  <= load_min_i;
      hour_q <= load_hour_i;
    end else if (upd_i) begin
      sec_q <= step_wrap(bin_i, sec_q, 7'd59);
      if (sec_top) begin
        min_q <= step_wrap(bin_i, min_q, 7'd59);
        if (min_top) hour_q <= step_hour(bin_i, h24_i, hour_q);
      end
    end
  end

  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hour_o = hour_q;

  AST_TIME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !load_i) |=> $stable({sec_q, min_q, hour_q})); // R7
  AST_MIN_ONLY_ON_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !load_i && !sec_top) |=> $stable({min_q, hour_q})); // R9

endmodule

// File: rtl/rtc_update_ctrl.sv
module rtc_update_ctrl #(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned LEAD_TICKS    = 8,
  parameter int unsigned UPD_TICKS     = 65
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [2:0] div_sel_i,
  input  logic       set_i,
  input  logic       bin_i,
  input  logic       h24_i,
  input  logic       load_i,
  input  logic [7:0] load_sec_i,
  input  logic [7:0] load_min_i,
  input  logic [7:0] load_hour_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic       uip_o,
  output logic       upd_done_o
);

  logic run, lead, sec_edge, upd, load_en;

  assign load_en = set_i && load_i;

  rtc_prescaler #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .LEAD_TICKS   (LEAD_TICKS)
  ) i_prescaler (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .div_sel_i(div_sel_i),
    .run_o    (run),
    .lead_o   (lead),
    .sec_o    (sec_edge)
  );

  rtc_update_fsm #(
    .UPD_TICKS(UPD_TICKS)
  ) i_fsm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .run_i (run),
    .set_i (set_i),
    .lead_i(lead),
    .sec_i (sec_edge),
    .uip_o (uip_o),
    .upd_o (upd),
    .done_o(upd_done_o)
  );

  rtc_time_counters i_counters (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_i      (upd),
    .load_i     (load_en),
    .bin_i      (bin_i),
    .h24_i      (h24_i),
    .load_sec_i (load_sec_i),
    .load_min_i (load_min_i),
    .load_hour_i(load_hour_i),
    .sec_o      (sec_o),
    .min_o      (min_o),
    .hour_o     (hour_o)
  );

  AST_LOAD_NEEDS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !set_i && !upd) |=> $stable({sec_o, min_o, hour_o})); // R8
  AST_SET_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> !upd_done_o); // R7

endmodule

// File: tb/test_rtc_update_ctrl.sv
module test_rtc_update_ctrl;

  localparam int TPS  = 16;
  localparam int LEAD = 3;
  localparam int LEN  = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] div_sel = 3'b110;
  logic       set = 1'b1;
  logic       bin = 1'b0;
  logic       h24 = 1'b1;
  logic       load = 1'b0;
  logic [7:0] ld_sec = '0, ld_min = '0, ld_hour = '0;
  logic [7:0] sec_o, min_o, hour_o;
  logic       uip_o, done_o;

  int checks = 0;
  int errors = 0;
  int k = 0;
  int p = 0;
  int t = 0;

  always #5 clk = ~clk;

  rtc_update_ctrl #(
    .TICKS_PER_SEC(TPS),
    .LEAD_TICKS   (LEAD),
    .UPD_TICKS    (LEN)
  ) i_rtc_update_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .div_sel_i  (div_sel),
    .set_i      (set),
    .bin_i      (bin),
    .h24_i      (h24),
    .load_i     (load),
    .load_sec_i (ld_sec),
    .load_min_i (ld_min),
    .load_hour_i(ld_hour),
    .sec_o      (sec_o),
    .min_o      (min_o),
    .hour_o     (hour_o),
    .uip_o      (uip_o),
    .upd_done_o (done_o)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] enc8(int v, bit bn);
    if (bn) return 8'(v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic logic [23:0] fmt(int tt, bit bn, bit hm);
    int hh = tt / 3600;
    int mm = (tt / 60) % 60;
    int ss = tt % 60;
    logic [7:0] hb;
    if (hm) hb = enc8(hh, bn);
    else begin
      int h12 = (hh % 12 == 0) ? 12 : hh % 12;
      hb = enc8(h12, bn) | ((hh >= 12) ? 8'h80 : 8'h00);
    end
    return {hb, enc8(mm, bn), enc8(ss, bn)};
  endfunction

  task automatic check_time(input string why);
    logic [23:0] e = fmt(t, bin, h24);
    string rf = bin ? "R9" : "R10";
    string rh = h24 ? "R11" : "R12";
    check({min_o, sec_o} == e[15:0], rf, {why, " min:sec"}, {min_o, sec_o}, e[15:0]);
    check(hour_o == e[23:16], rh, {why, " hour"}, hour_o, e[23:16]);
  endtask

  // one time-base tick, outputs sampled one cycle later
  task automatic step(input logic [2:0] dv, input bit sv, input string rq);
    bit eu, ed;
    @(negedge clk);
    div_sel = dv;
    set     = sv;
    tick    = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    if (dv == 3'b010) begin
      k++;
      p = k % TPS;
      if (!sv && k >= TPS && p == 0) t = (t + 1) % 86400;
    end else if (dv[2:1] == 2'b11) begin
      k = 0;
      p = 0;
    end
    eu = (dv == 3'b010) && !sv && ((p >= TPS - LEAD) || (k >= TPS && p < LEN));
    ed = (dv == 3'b010) && !sv && (k >= TPS) && (p == LEN);
    check(uip_o == eu, rq, "uip (R2/R3)", uip_o, eu);
    check(done_o == ed, "R4", "update-ended", done_o, ed);
    check_time(rq);
  endtask

  task automatic load_time(input int tt, input bit bn, input bit hm);
    logic [23:0] e = fmt(tt, bn, hm);
    @(negedge clk);
    set     = 1'b1;
    bin     = bn;
    h24     = hm;
    load    = 1'b1;
    ld_hour = e[23:16];
    ld_min  = e[15:8];
    ld_sec  = e[7:0];
    @(negedge clk);
    load = 1'b0;
    t = tt;
    check_time("R8 load under set");
  endtask

  int starts[5] = '{43198, 46798, 86398, 3598, 35998};

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(sec_o == 0 && min_o == 0 && hour_o == 0, "R1", "time after reset",
          {sec_o, min_o, hour_o}, 0);
    check(uip_o == 0, "R1", "uip after reset", uip_o, 0);
    check(done_o == 0, "R1", "done after reset", done_o, 0);

    for (int b = 0; b < 2; b++) begin
      for (int h = 0; h < 2; h++) begin
        foreach (starts[i]) begin
          load_time(starts[i], b[0], h[0]);
          step(3'b110, 1'b1, "R5");
          step(3'b111, 1'b0, "R5");
          step(3'b110, 1'b0, "R5");
          for (int n = 0; n < 4 * TPS + LEN + 2; n++) step(3'b010, 1'b0, "R5");
        end
      end
    end

    // set held for two seconds starting at phase 5
    while (p != 5) step(3'b010, 1'b0, "R2");
    for (int n = 0; n < 2 * TPS; n++) step(3'b010, 1'b1, "R7");
    for (int n = 0; n < TPS - 5; n++) step(3'b010, 1'b0, "R7");
    check(uip_o == 1'b1, "R7", "grid kept after set", uip_o, 1);

    // freeze with a non-run code, then resume
    while (p != 5) step(3'b010, 1'b0, "R6");
    for (int n = 0; n < 10; n++) step(3'b000, 1'b0, "R6");
    for (int n = 0; n < 3; n++) step(3'b011, 1'b0, "R6");
    for (int n = 0; n < TPS + LEN + 2; n++) step(3'b010, 1'b0, "R6");

    // load without set is ignored
    @(negedge clk);
    set     = 1'b0;
    load    = 1'b1;
    ld_sec  = 8'h33;
    ld_min  = 8'h22;
    ld_hour = 8'h11;
    @(negedge clk);
    load = 1'b0;
    @(negedge clk);
    check_time("R8 load ignored");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2ms;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule